// File: doc/BRIEF.md
# Programmable Countdown Timer with Latched Interrupt

This block is a word-addressed timer peripheral. Software programs a divisor, then writes a control word that chooses an operation and a tick source. A down-counter then steps once for each enable pulse from the chosen source. When the count is spent, the counter raises a raw interrupt bit. That bit stays set until software writes a one to the acknowledge offset. A mask register gates the raw bit onto one level-sensitive interrupt line.

Three operations are available. Load copies the divisor into the counter and counts down once. Run counts down over and over, reloading from the divisor on each wrap. Hold freezes the count. A separate 32-bit time counter advances on a fixed reference enable. The second timer's divisor and control and the watchdog control word are plain read/write placeholders. The bus accepts only full-word accesses. Any narrower access is flagged and changes nothing.

Top module: `tick_timer`

## Requirements
- R1: A synchronous active-high reset clears every register, the counter, the time counter and `irq`. After reset, control (0x08) reads 0x00000001: hold, clock select 0.
- R2: Writing control (0x08) with bits [1:0] = 0 (load) copies the divisor (0x00) into the counter at that write's clock edge. Each selected tick then decrements it. A tick at count 0 sets raw bit 0 and stops the counter, so there is exactly one interrupt, div+1 ticks after the load.
- R3: With bits [1:0] = 2 (run), a tick at count 0 reloads the divisor and sets raw bit 0, so the period is div+1 ticks. Writing the run code does not itself reload the counter.
- R4: Bits [1:0] = 1 (hold) and the illegal code 3 freeze the counter. Ticks have no effect.
- R5: Control bits [4:2] select the tick source. Codes 4, 5, 6 and 7 pick `srcTick[0]`, `[1]`, `[2]` and `[3]`. Codes 0 to 3 advance nothing. Pulses on sources that are not selected have no effect.
- R6: Raw bit 0 (read at 0x50) stays set until a word write to 0x4C with bit 0 = 1 clears it. Writing 0 there leaves it set. 0x4C reads 0. If an expiry and an acknowledge fall in the same cycle, the bit stays set.
- R7: The mask (0x48) reads and writes. 0x54 reads raw AND mask. `irq` is high exactly when that value is nonzero, and it follows a mask write or an acknowledge at the same clock edge.
- R8: An access with `busSize` other than 2 (0 = byte, 1 = halfword, 2 = word) drives `busErr` high in the same cycle. It changes no register, and a read of that kind returns 0.
- R9: The time counter (0x38) increments once per clock in which `refTick` is high and wraps on overflow.
- R10: The current count reads at 0x04. The second timer's divisor (0x10) reads back what was written. 0x14 and unmapped offsets read 0.
- R11: A load written while the timer runs reloads the counter from the divisor at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busSel | input | 1 | Access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset |
| busSize | input | 2 | 0 byte, 1 halfword, 2 word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, same cycle |
| busErr | output | 1 | Sub-word access flag |
| srcTick | input | 4 | Tick enables for clock select codes 4 to 7 |
| refTick | input | 1 | Reference enable for the time counter |
| irq | output | 1 | Level interrupt |

## Verification
An expiry and an acknowledge can land on the same clock edge, and the raw bit must survive that edge. The bench puts the timer in run mode with a divisor of 0, so every selected tick expires. In one cycle it then drives a tick on the selected source together with an acknowledge write of 1. Raw bit 0 and `irq` must still read 1 after that edge. A later acknowledge with no tick in the same cycle must clear them.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_DIV0  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_DATA0 = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_CTRL0 = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_DIV1  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_DATA1 = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_CTRL1 = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_TIME  = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_WDOG  = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_ACK   = 8'h4C;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_MSKD  = 8'h54;

  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_HOLD = 2'd1,
    OP_RUN  = 2'd2,
    OP_BAD  = 2'd3
  } tmrOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic reload;
    logic periodic;
    logic single;
  } tmrStrobe_t;
endpackage

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busErr,
  input  logic [DATA_W-1:0] count,
  input  logic [DATA_W-1:0] timeCnt,
  input  logic              expire,
  output tmrStrobe_t        st,
  output logic [SEL_W-1:0]  clkSel,
  output logic [DATA_W-1:0] divisor,
  output logic              rawIrq,
  output logic              irq
);
  localparam int SEL_LSB = 2;
  localparam logic [DATA_W-1:0] CTRL_RST = DATA_W'(OP_HOLD);

  logic [DATA_W-1:0] ctrlReg, div1Reg, ctrl1Reg, wdogReg, maskReg;
  logic wrOk, rdOk, ackClr;
  tmrOp_e opNow;

  assign busErr = busSel && (busSize != SZ_WORD);
  assign wrOk   = busSel && busWrite && !busErr;
  assign rdOk   = busSel && !busWrite && !busErr;
  assign ackClr = wrOk && (busAddr == OFS_ACK) && busWdata[0];

  assign opNow  = tmrOp_e'(ctrlReg[1:0]);
  assign clkSel = ctrlReg[SEL_LSB +: SEL_W];

  assign st.reload   = wrOk && (busAddr == OFS_CTRL0) && (busWdata[1:0] == OP_LOAD);
  assign st.periodic = (opNow == OP_RUN);
  assign st.single   = (opNow == OP_LOAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      divisor  <= '0;
      ctrlReg  <= CTRL_RST;
      div1Reg  <= '0;
      ctrl1Reg <= '0;
      wdogReg  <= '0;
      maskReg  <= '0;
    end else if (wrOk) begin
      case (busAddr)
        OFS_DIV0:  divisor  <= busWdata;
        OFS_CTRL0: ctrlReg  <= busWdata;
        OFS_DIV1:  div1Reg  <= busWdata;
        OFS_CTRL1: ctrl1Reg <= busWdata;
        OFS_WDOG:  wdogReg  <= busWdata;
        OFS_MASK:  maskReg  <= busWdata;
        default: ;
      endcase
    end
  end

  // a new expiry wins over a same-cycle acknowledge
  always_ff @(posedge clk) begin
    if (rst) rawIrq <= 1'b0;
    else     rawIrq <= (rawIrq && !ackClr) || expire;
  end

  assign irq = rawIrq && maskReg[0];

  always_comb begin
    busRdata = '0;
    if (rdOk) begin
      case (busAddr)
        OFS_DIV0:  busRdata = divisor;
        OFS_DATA0: busRdata = count;
        OFS_CTRL0: busRdata = ctrlReg;
        OFS_DIV1:  busRdata = div1Reg;
        OFS_CTRL1: busRdata = ctrl1Reg;
        OFS_TIME:  busRdata = timeCnt;
        OFS_WDOG:  busRdata = wdogReg;
        OFS_MASK:  busRdata = maskReg;
        OFS_RAW:   busRdata = DATA_W'(rawIrq);
        OFS_MSKD:  busRdata = DATA_W'(irq);
        default:   busRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int SEL_W    = 3,
  parameter int N_SRC    = 4,
  parameter int SRC_BASE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  tmrStrobe_t        st,
  input  logic [SEL_W-1:0]  clkSel,
  input  logic [DATA_W-1:0] divisor,
  input  logic [N_SRC-1:0]  srcTick,
  input  logic              refTick,
  output logic [DATA_W-1:0] count,
  output logic [DATA_W-1:0] timeCnt,
  output logic              expire
);
  logic [N_SRC-1:0] srcHit;
  logic tick, atZero, armed;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign srcHit[i] = srcTick[i] && (clkSel == SEL_W'(SRC_BASE + i));
  end

  assign tick   = |srcHit;
  assign atZero = (count == '0);
  assign expire = !st.reload && tick && atZero && (st.periodic || (st.single && armed));

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      armed <= 1'b0;
    end else if (st.reload) begin
      count <= divisor;
      armed <= 1'b1;
    end else if (tick && st.periodic) begin
      count <= atZero ? divisor : count - 1'b1;
    end else if (tick && st.single && armed) begin
      if (atZero) armed <= 1'b0;
      else        count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          timeCnt <= '0;
    else if (refTick) timeCnt <= timeCnt + 1'b1;
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int SEL_W    = 3,
  parameter int N_SRC    = 4,
  parameter int SRC_BASE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [7:0]        busAddr,
  input  logic [1:0]        busSize,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busErr,
  input  logic [N_SRC-1:0]  srcTick,
  input  logic              refTick,
  output logic              irq
);
  tmrStrobe_t        st;
  logic [SEL_W-1:0]  clkSel;
  logic [DATA_W-1:0] divisor, count, timeCnt;
  logic              expire, rawIrq;

  tick_timer_ctrl #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rst(rst), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .busRdata(busRdata), .busErr(busErr), .count(count),
    .timeCnt(timeCnt), .expire(expire), .st(st), .clkSel(clkSel),
    .divisor(divisor), .rawIrq(rawIrq), .irq(irq)
  );

  tick_timer_dp #(.DATA_W(DATA_W), .SEL_W(SEL_W), .N_SRC(N_SRC),
                  .SRC_BASE(SRC_BASE)) u_dp (
    .clk(clk), .rst(rst), .st(st), .clkSel(clkSel), .divisor(divisor),
    .srcTick(srcTick), .refTick(refTick), .count(count),
    .timeCnt(timeCnt), .expire(expire)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_timer_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int SEL_W    = 3,
  parameter int SRC_BASE = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              busSel,
  input logic              busWrite,
  input logic [7:0]        busAddr,
  input logic [1:0]        busSize,
  input logic [DATA_W-1:0] busWdata,
  input logic              busErr,
  input logic              refTick,
  input logic              irq,
  input tmrStrobe_t        st,
  input logic [SEL_W-1:0]  clkSel,
  input logic [DATA_W-1:0] count,
  input logic [DATA_W-1:0] timeCnt,
  input logic              expire,
  input logic              rawIrq
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!irq && count == '0 && timeCnt == '0));

  // R4
  hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (!st.reload && !st.periodic && !st.single) |=> $stable(count));

  // R5
  no_source_chk: assert property (@(posedge clk) disable iff (rst)
    (!st.reload && clkSel < SEL_W'(SRC_BASE)) |=> $stable(count));

  // R6
  expire_latch_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> rawIrq);

  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (busSel && busWrite && busSize == SZ_WORD && busAddr == OFS_ACK &&
     busWdata[0] && !expire) |=> !rawIrq);

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !rawIrq |-> !irq);

  // R8
  subword_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busSel && busWrite && busErr && !expire) |=> $stable(rawIrq));

  // R9
  time_step_chk: assert property (@(posedge clk) disable iff (rst)
    refTick |=> timeCnt == $past(timeCnt) + 1'b1);
endmodule

bind tick_timer tick_timer_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W),
                                 .SRC_BASE(SRC_BASE)) u_chk (.*);

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [1:0]  busSize = 2'd2;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busErr;
  logic [3:0]  srcTick = '0;
  logic        refTick = 1'b0;
  logic        irq;
  int nVec = 0, nBad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tick_timer u_dut (
    .clk(clk), .rst(rst), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .busRdata(busRdata), .busErr(busErr), .srcTick(srcTick),
    .refTick(refTick), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d; busSize = sz;
    #1;
    if (sz != 2'd2) check("R8 busErr on sub-word write", {31'b0, busErr}, 32'd1);
    @(negedge clk);
    busSel = 0; busWrite = 0; busSize = 2'd2;
  endtask

  task automatic rdChk(input string tag, input logic [7:0] a, input logic [31:0] exp,
                       input logic [1:0] sz = 2'd2);
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = a; busSize = sz;
    #1;
    check(tag, busRdata, exp);
    busSel = 0; busSize = 2'd2;
  endtask

  task automatic tickN(input logic [3:0] m, input int n);
    repeat (n) begin @(negedge clk); srcTick = m; end
    @(negedge clk); srcTick = '0;
  endtask

  task automatic testReset();
    rdChk("R1 ctrl after reset", 8'h08, 32'h1);
    rdChk("R1 count after reset", 8'h04, 32'h0);
    rdChk("R1 raw after reset", 8'h50, 32'h0);
    rdChk("R1 time after reset", 8'h38, 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'd0);
  endtask

  task automatic testSingle();
    wr(8'h48, 32'h1);
    wr(8'h00, 32'd3);
    wr(8'h08, 32'h14);
    rdChk("R2 count loaded", 8'h04, 32'd3);
    tickN(4'b0010, 3);
    rdChk("R2 count at zero", 8'h04, 32'd0);
    rdChk("R2 no irq before div+1 ticks", 8'h50, 32'd0);
    tickN(4'b0010, 1);
    rdChk("R2 raw set on expiry", 8'h50, 32'd1);
    check("R2 irq on expiry", {31'b0, irq}, 32'd1);
    tickN(4'b0010, 5);
    wr(8'h4C, 32'h1);
    tickN(4'b0010, 4);
    rdChk("R2 single shot only once", 8'h50, 32'd0);
    rdChk("R2 count stays at zero", 8'h04, 32'd0);
  endtask

  task automatic testRun();
    wr(8'h00, 32'd2);
    wr(8'h08, 32'h10);
    wr(8'h00, 32'd7);
    wr(8'h08, 32'h12);
    rdChk("R3 run write does not reload", 8'h04, 32'd2);
    tickN(4'b0001, 2);
    rdChk("R3 no raw before wrap", 8'h50, 32'd0);
    tickN(4'b0001, 1);
    rdChk("R3 raw on wrap", 8'h50, 32'd1);
    rdChk("R3 reload on wrap", 8'h04, 32'd7);
    wr(8'h4C, 32'h1);
    tickN(4'b0001, 7);
    rdChk("R3 no raw mid period", 8'h50, 32'd0);
    tickN(4'b0001, 1);
    rdChk("R3 periodic second wrap", 8'h50, 32'd1);
    wr(8'h4C, 32'h1);
    tickN(4'b0001, 3);
    wr(8'h08, 32'h10);
    rdChk("R11 load while running reloads", 8'h04, 32'd7);
    wr(8'h08, 32'h12);
  endtask

  task automatic testHold();
    wr(8'h08, 32'h11);
    tickN(4'b1111, 4);
    rdChk("R4 hold freezes count", 8'h04, 32'd7);
    wr(8'h08, 32'h13);
    tickN(4'b1111, 4);
    rdChk("R4 illegal op freezes count", 8'h04, 32'd7);
    rdChk("R4 ctrl readback", 8'h08, 32'h13);
  endtask

  task automatic testSelect();
    wr(8'h08, 32'h06);
    tickN(4'b1111, 3);
    rdChk("R5 select code 1 does not advance", 8'h04, 32'd7);
    wr(8'h08, 32'h1A);
    tickN(4'b1011, 3);
    rdChk("R5 unselected sources ignored", 8'h04, 32'd7);
    tickN(4'b0100, 2);
    rdChk("R5 select code 6 uses srcTick[2]", 8'h04, 32'd5);
    wr(8'h08, 32'h1E);
    tickN(4'b1000, 1);
    rdChk("R5 select code 7 uses srcTick[3]", 8'h04, 32'd4);
  endtask

  task automatic testCollide();
    wr(8'h4C, 32'h1);
    wr(8'h00, 32'd0);
    wr(8'h08, 32'h10);
    wr(8'h08, 32'h12);
    tickN(4'b0001, 1);
    rdChk("R6 expiry with div 0", 8'h50, 32'd1);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = 8'h4C; busWdata = 32'h1; srcTick = 4'b0001;
    @(negedge clk);
    busSel = 0; busWrite = 0; srcTick = '0;
    rdChk("R6 expiry beats same-cycle ack", 8'h50, 32'd1);
    check("R6 irq after collision", {31'b0, irq}, 32'd1);
  endtask

  task automatic testMask();
    wr(8'h48, 32'h0);
    check("R7 irq low when masked", {31'b0, irq}, 32'd0);
    rdChk("R7 masked value zero", 8'h54, 32'd0);
    rdChk("R7 raw still set", 8'h50, 32'd1);
    rdChk("R7 mask readback", 8'h48, 32'd0);
    wr(8'h48, 32'h1);
    check("R7 irq on unmask", {31'b0, irq}, 32'd1);
    rdChk("R7 masked value one", 8'h54, 32'd1);
    wr(8'h4C, 32'h0);
    rdChk("R6 ack of zero keeps raw", 8'h50, 32'd1);
    wr(8'h4C, 32'h1);
    rdChk("R6 ack clears raw", 8'h50, 32'd0);
    check("R7 irq drops on ack", {31'b0, irq}, 32'd0);
    rdChk("R6 ack reads zero", 8'h4C, 32'd0);
  endtask

  task automatic testSubword();
    wr(8'h08, 32'h11);
    wr(8'h00, 32'hAB, 2'd0);
    rdChk("R8 byte write ignored", 8'h00, 32'd0);
    wr(8'h48, 32'h0, 2'd1);
    rdChk("R8 halfword write ignored", 8'h48, 32'd1);
    rdChk("R8 sub-word read returns zero", 8'h08, 32'd0, 2'd1);
  endtask

  task automatic testTimeMap();
    repeat (5) begin @(negedge clk); refTick = 1; end
    @(negedge clk); refTick = 0;
    rdChk("R9 time counts ref ticks", 8'h38, 32'd5);
    wr(8'h10, 32'h55);
    rdChk("R10 timer1 divisor readback", 8'h10, 32'h55);
    rdChk("R10 timer1 data reads zero", 8'h14, 32'd0);
    rdChk("R10 unmapped reads zero", 8'h20, 32'd0);
    rdChk("R10 misaligned reads zero", 8'h05, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    testReset();
    testSingle();
    testRun();
    testHold();
    testSelect();
    testCollide();
    testMask();
    testSubword();
    testTimeMap();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule